// File: doc/BRIEF.md
# Shared Error Line Pulse Agent

This block is one agent's view of a shared error line that is active low. Any number of agents may pull the line down, so the resolved level is the wired-AND of everyone's drive. A local error request makes the agent pull the line low. Every event on the wire must show a low period of exactly `PULSE_LEN` clocks, three by default. This holds when several agents request at staggered times. To achieve it, each agent watches the resolved level on every clock. It counts how long the line has already been low and drives only for the clocks that remain in the window.

The agent also reports what it saw. It raises a one-cycle strobe on the first low sample of an event. When the event closes, it raises a one-cycle flush pulse, which the surrounding logic uses to clear its transaction queues, return its bus state machine to idle and reload its arbitration identity. With the same pulse, and only when logging is enabled, the agent gives a record that tells whether it took part in driving the event or only observed it.

There is no streaming data path. Every pin is a plain control or status level, and no back-pressure applies. The wire itself sits outside the block; a system ties the `drive_low` outputs of all agents into one wired-AND and returns the result on `line_n`.

Top module: `wor_err_agent`

## Requirements
- R1: Whenever `drive_low` is 1, the sampled wire `line_n` is 0 (drive active high, wire active low).
- R2: A request (`err_req` = 1 at a clock edge) at an edge where `line_n` is sampled high makes `drive_low` 1 for exactly `PULSE_LEN` cycles, starting in the cycle after that edge.
- R3: A request at an edge where the wire has been sampled low for n consecutive edges, with 1 <= n < `PULSE_LEN`, makes `drive_low` 1 for exactly `PULSE_LEN` - n cycles. It ends in the same cycle as the drive of the agent that opened the window.
- R4: A request at the edge of the `PULSE_LEN`-th consecutive low sample, or while the agent is already driving, starts no new drive and does not lengthen the current one.
- R5: With any request offsets among the agents on one wire, each event is a single low run of exactly `PULSE_LEN` cycles. A new run can start only once the wire has been sampled high, and a request on the first high sample after a run opens a new run.
- R6: `evt_strobe` is 1 for exactly one cycle per event, in the cycle after the first low sample.
- R7: `flush_pulse` is 1 for exactly one cycle per event, in the cycle after the `PULSE_LEN`-th low sample.
- R8: `rec_valid` is 1 together with `flush_pulse` only when `log_en` is 1 at that sampling edge. `rec_self` is 1 if the agent drove during any cycle of that event, and 0 if it only observed the event.
- R9: After reset, `drive_low`, `evt_strobe`, `flush_pulse`, `rec_valid` and `rec_self` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_req | input | 1 | Local request to signal an error, sampled each edge |
| line_n | input | 1 | Resolved shared line, 0 = asserted |
| log_en | input | 1 | Enables the event record |
| drive_low | output | 1 | 1 = this agent pulls the line low |
| evt_strobe | output | 1 | One-cycle strobe on the first low sample of an event |
| flush_pulse | output | 1 | One-cycle pulse when an event closes |
| rec_valid | output | 1 | Event record valid (only with log_en) |
| rec_self | output | 1 | Record: 1 = agent drove, 0 = only observed |

## Verification
The hardest cases to reach from the ports are joins on the second and third low sample of another agent's window, and a request that lands exactly on the closing low sample. Only a second agent driving the same wire can produce these, and the timing must be right to the clock. The bench puts three agents on one wired-AND line. It sweeps every combination of request offsets from zero to three clocks, including no request at all, for each agent. It then adds directed cases with a held request and with a request on the first high sample after a run.

// File: rtl/wor_pkg.sv
package wor_pkg;
  // event report produced when a low window closes
  typedef struct packed {
    logic valid;
    logic self;
  } wor_rec_t;
endpackage

// File: rtl/wor_line_mon.sv
module wor_line_mon #(
  parameter int PULSE_LEN = 3,
  parameter int CW = $clog2(PULSE_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_low,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nx,
  output logic          first_low,
  output logic          last_low,
  output logic          det_q
);
  localparam logic [CW-1:0] LEN_C = CW'(PULSE_LEN);

  // consecutive low samples, saturating at the window length
  always_comb begin
    if (!line_low)            cnt_nx = '0;
    else if (cnt_q == LEN_C)  cnt_nx = LEN_C;
    else                      cnt_nx = cnt_q + CW'(1);
  end

  assign first_low = line_low && (cnt_q == '0);
  assign last_low  = line_low && (cnt_q == LEN_C - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      det_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      det_q <= first_low;
    end
  end

  AST_WINDOW_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LEN_C) |-> !line_low); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    det_q |=> !det_q); // R6
endmodule

// File: rtl/wor_drv_timer.sv
module wor_drv_timer #(
  parameter int PULSE_LEN = 3,
  parameter int CW = $clog2(PULSE_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [CW-1:0] cnt_nx,
  output logic          drive
);
  localparam logic [CW-1:0] LEN_C = CW'(PULSE_LEN);

  logic [CW-1:0] left_q, left_d;

  // start fresh, join with the remaining clocks, or merge silently
  always_comb begin
    if (left_q != '0)                  left_d = left_q - CW'(1);
    else if (req && cnt_nx != LEN_C)   left_d = LEN_C - cnt_nx;
    else                               left_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign drive = (left_q != '0);

  AST_REQ_NO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
    (drive && req) |=> (left_q < $past(left_q))); // R4
endmodule

// File: rtl/wor_event_log.sv
module wor_event_log
  import wor_pkg::*;
#(
  parameter int PULSE_LEN = 3,
  parameter int CW = $clog2(PULSE_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_nx,
  input  logic          last_low,
  input  logic          drive,
  input  logic          log_en,
  output logic          flush,
  output wor_rec_t      rec
);
  logic mine_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mine_q <= 1'b0;
      flush  <= 1'b0;
      rec    <= '0;
    end else begin
      mine_q    <= (cnt_nx == '0 || last_low) ? 1'b0 : (mine_q | drive);
      flush     <= last_low;
      rec.valid <= last_low && log_en;
      rec.self  <= last_low && (mine_q | drive);
    end
  end

  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush); // R7
  AST_REC_WITH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    rec.valid |-> flush); // R8
endmodule

// File: rtl/wor_err_agent.sv
module wor_err_agent
  import wor_pkg::*;
#(
  parameter int PULSE_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_req,
  input  logic line_n,
  input  logic log_en,
  output logic drive_low,
  output logic evt_strobe,
  output logic flush_pulse,
  output logic rec_valid,
  output logic rec_self
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LEN_C = CW'(PULSE_LEN);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic          first_low, last_low;
  wor_rec_t      rec;

  wor_line_mon #(.PULSE_LEN(PULSE_LEN), .CW(CW)) u_mon (
    .clk(clk), .rst_n(rst_n), .line_low(!line_n),
    .cnt_q(cnt_q), .cnt_nx(cnt_nx),
    .first_low(first_low), .last_low(last_low), .det_q(evt_strobe)
  );

  wor_drv_timer #(.PULSE_LEN(PULSE_LEN), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .req(err_req),
    .cnt_nx(cnt_nx), .drive(drive_low)
  );

  wor_event_log #(.PULSE_LEN(PULSE_LEN), .CW(CW)) u_log (
    .clk(clk), .rst_n(rst_n), .cnt_nx(cnt_nx), .last_low(last_low),
    .drive(drive_low), .log_en(log_en), .flush(flush_pulse), .rec(rec)
  );

  assign rec_valid = rec.valid;
  assign rec_self  = rec.self;

  AST_DRIVE_PULLS: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low |-> !line_n); // R1
  AST_DRIVE_ENDS_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_low) |-> (cnt_q == LEN_C)); // R3
  AST_FLUSH_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> !evt_strobe); // R7
endmodule

// File: tb/test_wor_err_agent.sv
`timescale 1ns/1ps
module test_wor_err_agent;
  localparam int NA = 3;
  localparam int LEN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NA-1:0] req = '0;
  logic log_en = 1'b0;
  logic [NA-1:0] drv, strb, fl, rv, rs;
  logic line_n;

  always #2.5 clk = ~clk;

  assign line_n = ~|drv;

  for (genvar g = 0; g < NA; g++) begin : g_agent
    wor_err_agent #(.PULSE_LEN(LEN)) i_wor_err_agent (
      .clk(clk), .rst_n(rst_n), .err_req(req[g]), .line_n(line_n),
      .log_en(log_en), .drive_low(drv[g]), .evt_strobe(strb[g]),
      .flush_pulse(fl[g]), .rec_valid(rv[g]), .rec_self(rs[g])
    );
  end

  int checks = 0;
  int fails = 0;
  int low_total, low_runs, r1_bad;
  int dcnt[NA], scnt[NA], fcnt[NA], rcnt[NA];
  logic rself[NA];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // masks: bit k = request at the edge following negedge k
  task automatic run_case(input logic [7:0] m0, input logic [7:0] m1,
                          input logic [7:0] m2, input logic le);
    logic prev_low;
    prev_low = 1'b0;
    low_total = 0; low_runs = 0; r1_bad = 0;
    for (int i = 0; i < NA; i++) begin
      dcnt[i] = 0; scnt[i] = 0; fcnt[i] = 0; rcnt[i] = 0; rself[i] = 1'b0;
    end
    log_en = le;
    for (int k = 0; k < 18; k++) begin
      @(negedge clk);
      if (!line_n) begin
        low_total++;
        if (!prev_low) low_runs++;
      end
      prev_low = !line_n;
      for (int i = 0; i < NA; i++) begin
        if (drv[i]) begin
          dcnt[i]++;
          if (line_n) r1_bad++;
        end
        if (strb[i]) scnt[i]++;
        if (fl[i]) fcnt[i]++;
        if (rv[i]) begin
          rcnt[i]++;
          rself[i] = rs[i];
        end
      end
      req[0] = (k < 8) ? m0[k] : 1'b0;
      req[1] = (k < 8) ? m1[k] : 1'b0;
      req[2] = (k < 8) ? m2[k] : 1'b0;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int off[NA];
    int t0, rel, ed, combo;
    logic [7:0] mk[NA];
    repeat (3) @(negedge clk);
    // R9: reset values
    chk(drv == '0, "R9 drive_low after reset", int'(drv), 0);
    chk((strb | fl | rv | rs) == '0, "R9 status after reset", int'(strb | fl | rv | rs), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(line_n == 1'b1, "R9 wire idle", int'(line_n), 1);

    combo = 0;
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++)
        for (int c = 0; c < 5; c++) begin
          if (a == 4 && b == 4 && c == 4) continue;
          off[0] = a; off[1] = b; off[2] = c;
          t0 = 4;
          for (int i = 0; i < NA; i++) begin
            if (off[i] < t0) t0 = off[i];
            mk[i] = (off[i] < 4) ? (8'd1 << off[i]) : 8'd0;
          end
          combo++;
          run_case(mk[0], mk[1], mk[2], combo[0]);
          chk(low_total == LEN, "R5 low length", low_total, LEN);
          chk(low_runs == 1, "R5 single run", low_runs, 1);
          chk(r1_bad == 0, "R1 drive implies wire low", r1_bad, 0);
          for (int i = 0; i < NA; i++) begin
            rel = off[i] - t0;
            ed = (off[i] < 4 && rel < LEN) ? LEN - rel : 0;
            if (off[i] < 4 && rel == 0)
              chk(dcnt[i] == ed, "R2 fresh drive length", dcnt[i], ed);
            else if (off[i] < 4 && rel < LEN)
              chk(dcnt[i] == ed, "R3 join drive length", dcnt[i], ed);
            else
              chk(dcnt[i] == ed, "R4 no drive after close or idle", dcnt[i], ed);
            chk(scnt[i] == 1, "R6 strobe count", scnt[i], 1);
            chk(fcnt[i] == 1, "R7 flush count", fcnt[i], 1);
            chk(rcnt[i] == int'(combo[0]), "R8 record gating", rcnt[i], int'(combo[0]));
            if (combo[0])
              chk(rself[i] == (ed > 0), "R8 record self flag", int'(rself[i]), int'(ed > 0));
          end
        end

    // R4: held request while already driving does not extend
    run_case(8'b0000_0111, 8'd0, 8'd0, 1'b1);
    chk(dcnt[0] == LEN, "R4 held request drive length", dcnt[0], LEN);
    chk(low_total == LEN, "R4 held request wire length", low_total, LEN);
    chk(rself[0] == 1'b1 && rself[1] == 1'b0, "R8 driver vs observer",
        int'({rself[0], rself[1]}), 2);

    // R5: request on the first high sample after a run opens a new run
    run_case(8'b0000_0001, 8'b0001_0000, 8'd0, 1'b0);
    chk(low_runs == 2, "R5 second run", low_runs, 2);
    chk(low_total == 2 * LEN, "R5 two run total", low_total, 2 * LEN);
    chk(dcnt[1] == LEN, "R5 new run full drive", dcnt[1], LEN);
    chk(scnt[2] == 2, "R6 strobe per run", scnt[2], 2);
    chk(rcnt[0] == 0, "R8 no record when disabled", rcnt[0], 0);

    finish_run();
  end
endmodule